// File: doc/BRIEF.md
# Join-Counting Unit Dispatcher

This block is a supervisory dispatcher that sits in front of a small set of processing units. Instruction sequences send it selection requests. Each request names a target unit, a required call count and a 15-bit sequence address. A request waits in its unit's queue until enough calls for the same address have arrived and the unit is idle. It is then handed to the unit as a dispatch strobe carrying the unit number and the address. Each unit's queue is a linked list threaded through a small shared pool of entries. Every entry holds an address tag, a required count, an arrival count and a link to the next entry.

The dispatcher also handles two other kinds of submission. A fork parks the submitter's current address on a supervisory queue and redirects execution to a branch address. An error report parks the current address in the same way and redirects execution to a fixed diagnostic address. The supervisory queue uses the same pool and shows its oldest entry until a consumer pops it. Units report completion with a done pulse, which either releases the next ready request or marks the unit available.

Top module: `join_dispatch`

## Requirements
- R1: After reset, every unit is available, the dispatch, redirect and overflow outputs are low, and the supervisory queue is empty.
- R2: A selection (kind code 0) with count N is dispatched only after N selections to the same unit and address have arrived. A count of 0 acts as 1. Further calls to a waiting entry are merged into it and never produce a second dispatch.
- R3: When the last needed call is sampled at a clock edge and the unit is available, `disp_valid_o` is high for one cycle after the following edge, carrying the unit number and address. The unit's bit in `unit_busy_o` is high from that same cycle.
- R4: Requests for one unit leave in arrival order. A later request whose count is met never overtakes an earlier request whose count is not yet met.
- R5: A done pulse sampled at an edge dispatches the unit's head request at that same edge if its count is met. Otherwise the unit's busy bit is low after that edge.
- R6: When several units can take work in the same cycle, only the lowest-numbered unit is dispatched in that cycle. The others follow in later cycles in rising order.
- R7: A fork (kind code 1) raises `redir_valid_o` for one cycle after the sampling edge, with `redir_addr_o` equal to the branch address. It also appends the current address to the supervisory queue. `sup_addr_o` shows the oldest entry while `sup_valid_o` is high, and `sup_pop_i` removes that entry.
- R8: An error report (kind code 2) redirects to the parameter `DIAG_ADDR` (default 0x7F00) and appends the current address to the supervisory queue.
- R9: The pool holds `SLOTS` entries (default 8) across all queues. A submission that needs a new entry when the pool is full raises `ovf_o` for one cycle, queues nothing and does not redirect. A call that merges into an existing entry is still accepted.
- R10: A pop while the supervisory queue is empty, and a done pulse to an available unit, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid_i | input | 1 | Submission strobe, at most one per cycle |
| sub_kind_i | input | 2 | 0 selection, 1 fork, 2 error report |
| sub_unit_i | input | log2(NUM_UNITS) | Target unit of a selection |
| sub_count_i | input | CNT_W | Calls required before dispatch |
| sub_addr_i | input | ADDR_W | Sequence address (selection) or current address (fork, error) |
| sub_branch_i | input | ADDR_W | Branch address of a fork |
| done_i | input | NUM_UNITS | Completion pulse per unit |
| sup_pop_i | input | 1 | Remove the oldest supervisory entry |
| disp_valid_o | output | 1 | Dispatch strobe |
| disp_unit_o | output | log2(NUM_UNITS) | Unit receiving the dispatch |
| disp_addr_o | output | ADDR_W | Address of the dispatched request |
| redir_valid_o | output | 1 | Redirect strobe |
| redir_addr_o | output | ADDR_W | Address where execution continues |
| sup_valid_o | output | 1 | Supervisory queue not empty |
| sup_addr_o | output | ADDR_W | Oldest supervisory address |
| unit_busy_o | output | NUM_UNITS | Busy flag per unit |
| ovf_o | output | 1 | Entry pool exhausted, submission dropped |

## Verification
The hardest case to reach is a pool that is exactly full while one unit still holds an unfinished join. In that state, a further call to the waiting address must be merged, while any new address must be dropped with an overflow. The stimulus gets there in steps. It first makes one unit busy, parks a partly counted request behind it, and then fills the remaining entries with forks. It then checks both kinds of call before draining everything. Head-of-line blocking is reached the same way: a unit is kept busy while an unready request and a ready request queue behind it.

// File: rtl/jd_pkg.sv
package jd_pkg;
  typedef enum logic [1:0] {
    KIND_SEL  = 2'd0,
    KIND_FORK = 2'd1,
    KIND_ERR  = 2'd2
  } jd_kind_e;
endpackage

// File: rtl/jd_first_set.sv
module jd_first_set #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |req_i;

  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/jd_queue_ptrs.sv
module jd_queue_ptrs #(
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [SLOT_W-1:0] push_slot_i,
  input  logic [SLOT_W-1:0] head_next_i,
  output logic [SLOT_W-1:0] head_o,
  output logic [SLOT_W-1:0] tail_o,
  output logic              empty_o,
  output logic              link_we_o
);
  logic drains;

  // queue becomes empty this cycle before any append
  assign drains    = empty_o || (pop_i && (head_o == tail_o));
  assign link_we_o = push_i && !drains;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_o  <= '0;
      tail_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      if (pop_i && !empty_o) begin
        if (head_o == tail_o) empty_o <= 1'b1;
        else                  head_o  <= head_next_i;
      end
      if (push_i) begin
        tail_o <= push_slot_i;
        if (drains) begin
          head_o  <= push_slot_i;
          empty_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/join_dispatch.sv
module join_dispatch #(
  parameter int          NUM_UNITS = 4,
  parameter int          ADDR_W    = 15,
  parameter int          CNT_W     = 4,
  parameter int          SLOTS     = 8,
  parameter int unsigned DIAG_ADDR = 32'h7F00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sub_valid_i,
  input  logic [1:0]                   sub_kind_i,
  input  logic [$clog2(NUM_UNITS)-1:0] sub_unit_i,
  input  logic [CNT_W-1:0]             sub_count_i,
  input  logic [ADDR_W-1:0]            sub_addr_i,
  input  logic [ADDR_W-1:0]            sub_branch_i,
  input  logic [NUM_UNITS-1:0]         done_i,
  input  logic                         sup_pop_i,
  output logic                         disp_valid_o,
  output logic [$clog2(NUM_UNITS)-1:0] disp_unit_o,
  output logic [ADDR_W-1:0]            disp_addr_o,
  output logic                         redir_valid_o,
  output logic [ADDR_W-1:0]            redir_addr_o,
  output logic                         sup_valid_o,
  output logic [ADDR_W-1:0]            sup_addr_o,
  output logic [NUM_UNITS-1:0]         unit_busy_o,
  output logic                         ovf_o
);
  import jd_pkg::*;

  localparam int UNIT_W = $clog2(NUM_UNITS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int NQ     = NUM_UNITS + 1;
  localparam int SUP_Q  = NUM_UNITS;
  localparam int OWN_W  = $clog2(NQ);

  function automatic logic [CNT_W-1:0] need_of(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + CNT_W'(1);
  endfunction

  function automatic logic met(input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] need);
    return got >= need;
  endfunction

  // entry pool
  logic [SLOTS-1:0]  s_valid;
  logic [ADDR_W-1:0] s_addr  [SLOTS];
  logic [CNT_W-1:0]  s_need  [SLOTS];
  logic [CNT_W-1:0]  s_got   [SLOTS];
  logic [SLOT_W-1:0] s_next  [SLOTS];
  logic [OWN_W-1:0]  s_owner [SLOTS];

  // queue pointers
  logic [SLOT_W-1:0] q_head [NQ];
  logic [SLOT_W-1:0] q_tail [NQ];
  logic [NQ-1:0]     q_empty;
  logic [NQ-1:0]     q_pop;
  logic [NQ-1:0]     q_push;
  logic [NQ-1:0]     q_link_we;

  logic [NUM_UNITS-1:0] busy;
  logic [NUM_UNITS-1:0] unit_ready;

  // named events for the checker
  logic              is_sel, is_fork, is_err, is_park;
  logic              go_any;
  logic [UNIT_W-1:0] go_unit;
  logic [SLOT_W-1:0] pop_slot;
  logic              sup_pop_ok;
  logic [SLOTS-1:0]  match;
  logic              hit_any, free_any;
  logic [SLOT_W-1:0] hit_idx, free_idx;
  logic              ev_join, ev_alloc, ev_ovf;
  logic [OWN_W-1:0]  alloc_q;

  assign is_sel  = sub_valid_i && (sub_kind_i == KIND_SEL);
  assign is_fork = sub_valid_i && (sub_kind_i == KIND_FORK);
  assign is_err  = sub_valid_i && (sub_kind_i == KIND_ERR);
  assign is_park = is_fork || is_err;

  genvar gu;
  generate
    for (gu = 0; gu < NUM_UNITS; gu++) begin : g_ready
      assign unit_ready[gu] = !q_empty[gu]
                              && met(s_got[q_head[gu]], s_need[q_head[gu]])
                              && (!busy[gu] || done_i[gu]);
    end
  endgenerate

  jd_first_set #(.N(NUM_UNITS), .IDX_W(UNIT_W)) u_arb (
    .req_i (unit_ready),
    .any_o (go_any),
    .idx_o (go_unit)
  );

  assign pop_slot   = q_head[go_unit];
  assign sup_pop_ok = sup_pop_i && !q_empty[SUP_Q];

  // an entry leaving this cycle takes no further calls
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      match[i] = s_valid[i]
                 && (s_owner[i] == OWN_W'(sub_unit_i))
                 && (s_addr[i] == sub_addr_i)
                 && !(go_any && (SLOT_W'(i) == pop_slot));
    end
  end

  jd_first_set #(.N(SLOTS), .IDX_W(SLOT_W)) u_hit (
    .req_i (match),
    .any_o (hit_any),
    .idx_o (hit_idx)
  );

  jd_first_set #(.N(SLOTS), .IDX_W(SLOT_W)) u_free (
    .req_i (~s_valid),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  assign ev_join  = is_sel && hit_any;
  assign ev_alloc = ((is_sel && !hit_any) || is_park) && free_any;
  assign ev_ovf   = ((is_sel && !hit_any) || is_park) && !free_any;
  assign alloc_q  = is_park ? OWN_W'(SUP_Q) : OWN_W'(sub_unit_i);

  genvar gq;
  generate
    for (gq = 0; gq < NQ; gq++) begin : g_q
      if (gq == SUP_Q) begin : g_sup
        assign q_pop[gq] = sup_pop_ok;
      end else begin : g_unit
        assign q_pop[gq] = go_any && (go_unit == UNIT_W'(gq));
      end
      assign q_push[gq] = ev_alloc && (alloc_q == OWN_W'(gq));

      jd_queue_ptrs #(.SLOT_W(SLOT_W)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (q_pop[gq]),
        .push_i      (q_push[gq]),
        .push_slot_i (free_idx),
        .head_next_i (s_next[q_head[gq]]),
        .head_o      (q_head[gq]),
        .tail_o      (q_tail[gq]),
        .empty_o     (q_empty[gq]),
        .link_we_o   (q_link_we[gq])
      );
    end
  endgenerate

  // occupancy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= '0;
    end else begin
      if (go_any)     s_valid[pop_slot]     <= 1'b0;
      if (sup_pop_ok) s_valid[q_head[SUP_Q]] <= 1'b0;
      if (ev_alloc)   s_valid[free_idx]     <= 1'b1;
    end
  end

  // entry contents and links
  always_ff @(posedge clk) begin
    if (ev_join) s_got[hit_idx] <= bump(s_got[hit_idx]);
    if (ev_alloc) begin
      s_addr[free_idx]  <= sub_addr_i;
      s_need[free_idx]  <= is_park ? CNT_W'(1) : need_of(sub_count_i);
      s_got[free_idx]   <= CNT_W'(1);
      s_owner[free_idx] <= alloc_q;
    end
    for (int q = 0; q < NQ; q++) begin
      if (q_link_we[q]) s_next[q_tail[q]] <= free_idx;
    end
  end

  // unit status and outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= '0;
      disp_valid_o  <= 1'b0;
      disp_unit_o   <= '0;
      disp_addr_o   <= '0;
      redir_valid_o <= 1'b0;
      redir_addr_o  <= '0;
      ovf_o         <= 1'b0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (go_any && (go_unit == UNIT_W'(u))) busy[u] <= 1'b1;
        else if (done_i[u])                    busy[u] <= 1'b0;
      end
      disp_valid_o <= go_any;
      if (go_any) begin
        disp_unit_o <= go_unit;
        disp_addr_o <= s_addr[pop_slot];
      end
      redir_valid_o <= is_park && free_any;
      if (is_park && free_any)
        redir_addr_o <= is_fork ? sub_branch_i : ADDR_W'(DIAG_ADDR);
      ovf_o <= ev_ovf;
    end
  end

  assign unit_busy_o = busy;
  assign sup_valid_o = !q_empty[SUP_Q];
  assign sup_addr_o  = s_addr[q_head[SUP_Q]];
endmodule

// File: rtl/join_dispatch_chk.sv
module join_dispatch_chk #(
  parameter int NUM_UNITS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         disp_valid_o,
  input logic [$clog2(NUM_UNITS)-1:0] disp_unit_o,
  input logic [NUM_UNITS-1:0]         unit_busy_o,
  input logic [NUM_UNITS-1:0]         done_i,
  input logic                         redir_valid_o,
  input logic                         ovf_o,
  input logic                         sub_valid_i,
  input logic [1:0]                   sub_kind_i,
  input logic                         sup_valid_o,
  input logic                         sup_pop_i,
  input logic                         ev_join,
  input logic                         ev_alloc,
  input logic                         ev_ovf
);
  logic [NUM_UNITS-1:0] free_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) free_prev <= '1;
    else        free_prev <= ~unit_busy_o | done_i;
  end

  // R3
  disp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> unit_busy_o[disp_unit_o]);

  // R3
  disp_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> free_prev[disp_unit_o]);

  // R7
  redir_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |-> $past(sub_valid_i && (sub_kind_i != 2'd0)));

  // R9
  ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && redir_valid_o));

  // R9
  outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_join, ev_alloc, ev_ovf}));

  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_valid_o && sup_pop_i && !sub_valid_i) |=> !sup_valid_o);
endmodule

bind join_dispatch join_dispatch_chk #(.NUM_UNITS(NUM_UNITS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .disp_valid_o  (disp_valid_o),
  .disp_unit_o   (disp_unit_o),
  .unit_busy_o   (unit_busy_o),
  .done_i        (done_i),
  .redir_valid_o (redir_valid_o),
  .ovf_o         (ovf_o),
  .sub_valid_i   (sub_valid_i),
  .sub_kind_i    (sub_kind_i),
  .sup_valid_o   (sup_valid_o),
  .sup_pop_i     (sup_pop_i),
  .ev_join       (ev_join),
  .ev_alloc      (ev_alloc),
  .ev_ovf        (ev_ovf)
);

// File: tb/join_dispatch_tb_top.sv
module join_dispatch_tb_top;
  localparam int NU = 4;
  localparam int AW = 15;
  localparam int CW = 4;
  localparam int DIAG = 32'h7F00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sub_valid_i = 1'b0;
  logic [1:0]    sub_kind_i = '0;
  logic [1:0]    sub_unit_i = '0;
  logic [CW-1:0] sub_count_i = '0;
  logic [AW-1:0] sub_addr_i = '0;
  logic [AW-1:0] sub_branch_i = '0;
  logic [NU-1:0] done_i = '0;
  logic          sup_pop_i = 1'b0;
  logic          disp_valid_o;
  logic [1:0]    disp_unit_o;
  logic [AW-1:0] disp_addr_o;
  logic          redir_valid_o;
  logic [AW-1:0] redir_addr_o;
  logic          sup_valid_o;
  logic [AW-1:0] sup_addr_o;
  logic [NU-1:0] unit_busy_o;
  logic          ovf_o;

  int checks = 0;
  int errors = 0;
  bit over = 1'b0;

  int    exp_unit[$];
  int    exp_addr[$];
  string exp_tag[$];

  always #4 clk = ~clk;

  join_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .sub_valid_i(sub_valid_i), .sub_kind_i(sub_kind_i),
    .sub_unit_i(sub_unit_i), .sub_count_i(sub_count_i), .sub_addr_i(sub_addr_i),
    .sub_branch_i(sub_branch_i), .done_i(done_i), .sup_pop_i(sup_pop_i),
    .disp_valid_o(disp_valid_o), .disp_unit_o(disp_unit_o), .disp_addr_o(disp_addr_o),
    .redir_valid_o(redir_valid_o), .redir_addr_o(redir_addr_o),
    .sup_valid_o(sup_valid_o), .sup_addr_o(sup_addr_o),
    .unit_busy_o(unit_busy_o), .ovf_o(ovf_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_disp(int u, int a, string tag);
    exp_unit.push_back(u);
    exp_addr.push_back(a);
    exp_tag.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && disp_valid_o) begin
      if (exp_unit.size() == 0) begin
        chk(1'b0, "R4", "unexpected dispatch addr", int'(disp_addr_o), 0);
      end else begin
        int u;
        int a;
        string t;
        u = exp_unit.pop_front();
        a = exp_addr.pop_front();
        t = exp_tag.pop_front();
        chk(int'(disp_unit_o) == u, t, "dispatch unit", int'(disp_unit_o), u);
        chk(int'(disp_addr_o) == a, t, "dispatch addr", int'(disp_addr_o), a);
      end
    end
  end

  // caller stands at a falling edge
  task automatic submit(logic [1:0] k, int u, int c, int a, int b);
    sub_valid_i  = 1'b1;
    sub_kind_i   = k;
    sub_unit_i   = 2'(u);
    sub_count_i  = CW'(c);
    sub_addr_i   = AW'(a);
    sub_branch_i = AW'(b);
    @(negedge clk);
    sub_valid_i = 1'b0;
  endtask

  task automatic finish_units(logic [NU-1:0] m);
    done_i = m;
    @(negedge clk);
    done_i = '0;
  endtask

  task automatic pop_sup();
    sup_pop_i = 1'b1;
    @(negedge clk);
    sup_pop_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(string tag);
    idle(6);
    chk(exp_unit.size() == 0, tag, "dispatches still pending", exp_unit.size(), 0);
  endtask

  task automatic summary();
    if (!over) begin
      over = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(unit_busy_o == '0, "R1", "busy after reset", int'(unit_busy_o), 0);
    chk(!disp_valid_o && !redir_valid_o && !ovf_o, "R1", "strobes after reset",
        int'({disp_valid_o, redir_valid_o, ovf_o}), 0);
    chk(!sup_valid_o, "R1", "supervisory queue after reset", int'(sup_valid_o), 0);

    // R3 single call dispatch timing
    expect_disp(0, 'h0123, "R3");
    submit(jd_pkg::KIND_SEL, 0, 1, 'h0123, 0);
    chk(!disp_valid_o, "R3", "dispatch one edge early", int'(disp_valid_o), 0);
    idle(1);
    chk(disp_valid_o, "R3", "dispatch strobe", int'(disp_valid_o), 1);
    chk(unit_busy_o[0], "R3", "unit 0 busy", int'(unit_busy_o[0]), 1);
    drain("R3");

    // R2 join of three calls, count zero acts as one
    submit(jd_pkg::KIND_SEL, 1, 3, 'h0200, 0);
    submit(jd_pkg::KIND_SEL, 1, 3, 'h0200, 0);
    idle(4);
    chk(!unit_busy_o[1], "R2", "unit 1 taken before join", int'(unit_busy_o[1]), 0);
    expect_disp(1, 'h0200, "R2");
    submit(jd_pkg::KIND_SEL, 1, 3, 'h0200, 0);
    idle(1);
    chk(disp_valid_o, "R2", "join complete dispatch", int'(disp_valid_o), 1);
    expect_disp(3, 'h0311, "R2");
    submit(jd_pkg::KIND_SEL, 3, 0, 'h0311, 0);
    drain("R2");

    // R4 FIFO with unready head, merged extra call
    submit(jd_pkg::KIND_SEL, 0, 2, 'h0400, 0);
    submit(jd_pkg::KIND_SEL, 0, 1, 'h0401, 0);
    submit(jd_pkg::KIND_SEL, 0, 1, 'h0401, 0);
    finish_units(4'b0001);
    // R5 head not ready leaves unit available
    chk(!unit_busy_o[0], "R5", "unit 0 released", int'(unit_busy_o[0]), 0);
    idle(4);
    chk(!unit_busy_o[0], "R4", "ready entry overtook head", int'(unit_busy_o[0]), 0);
    expect_disp(0, 'h0400, "R4");
    expect_disp(0, 'h0401, "R4");
    submit(jd_pkg::KIND_SEL, 0, 2, 'h0400, 0);
    idle(5);
    chk(exp_unit.size() == 1, "R4", "second entry waits for done", exp_unit.size(), 1);
    finish_units(4'b0001);
    chk(disp_valid_o && disp_addr_o == AW'('h0401), "R5", "dispatch at done edge",
        int'(disp_addr_o), 'h0401);
    drain("R4");

    // R10 done to idle unit 2 ignored
    finish_units(4'b1111);
    chk(unit_busy_o == '0, "R10", "all units available", int'(unit_busy_o), 0);

    // R6 simultaneous completion
    expect_disp(0, 'h0500, "R6");
    expect_disp(1, 'h0510, "R6");
    submit(jd_pkg::KIND_SEL, 0, 1, 'h0500, 0);
    submit(jd_pkg::KIND_SEL, 1, 1, 'h0510, 0);
    drain("R6");
    submit(jd_pkg::KIND_SEL, 0, 1, 'h0501, 0);
    submit(jd_pkg::KIND_SEL, 1, 1, 'h0511, 0);
    idle(3);
    expect_disp(0, 'h0501, "R6");
    expect_disp(1, 'h0511, "R6");
    finish_units(4'b0011);
    chk(disp_valid_o && disp_unit_o == 2'd0, "R6", "lowest unit first", int'(disp_unit_o), 0);
    idle(1);
    chk(disp_valid_o && disp_unit_o == 2'd1, "R6", "next unit follows", int'(disp_unit_o), 1);
    drain("R6");
    finish_units(4'b0011);
    chk(unit_busy_o == '0, "R5", "units released", int'(unit_busy_o), 0);

    // R7 fork and R8 error report
    submit(jd_pkg::KIND_FORK, 0, 0, 'h0600, 'h0700);
    chk(redir_valid_o && redir_addr_o == AW'('h0700), "R7", "fork redirect",
        int'(redir_addr_o), 'h0700);
    chk(sup_valid_o && sup_addr_o == AW'('h0600), "R7", "parked address",
        int'(sup_addr_o), 'h0600);
    submit(jd_pkg::KIND_FORK, 0, 0, 'h0601, 'h0710);
    chk(redir_addr_o == AW'('h0710), "R7", "second fork redirect", int'(redir_addr_o), 'h0710);
    submit(jd_pkg::KIND_ERR, 0, 0, 'h0602, 0);
    chk(redir_valid_o && redir_addr_o == AW'(DIAG), "R8", "diagnostic redirect",
        int'(redir_addr_o), DIAG);
    chk(sup_addr_o == AW'('h0600), "R7", "oldest stays at head", int'(sup_addr_o), 'h0600);
    pop_sup();
    chk(sup_addr_o == AW'('h0601), "R7", "second parked", int'(sup_addr_o), 'h0601);
    pop_sup();
    chk(sup_addr_o == AW'('h0602), "R8", "error parked", int'(sup_addr_o), 'h0602);
    pop_sup();
    chk(!sup_valid_o, "R7", "queue drained", int'(sup_valid_o), 0);
    pop_sup();
    chk(!sup_valid_o, "R10", "pop on empty", int'(sup_valid_o), 0);
    submit(jd_pkg::KIND_FORK, 0, 0, 'h0603, 'h0720);
    chk(sup_valid_o && sup_addr_o == AW'('h0603), "R10", "queue intact after empty pop",
        int'(sup_addr_o), 'h0603);
    pop_sup();

    // R9 pool exhaustion
    expect_disp(2, 'h0900, "R9");
    submit(jd_pkg::KIND_SEL, 2, 1, 'h0900, 0);
    drain("R9");
    submit(jd_pkg::KIND_SEL, 2, 2, 'h0901, 0);
    for (int i = 0; i < 7; i++) submit(jd_pkg::KIND_FORK, 0, 0, 'h0800 + i, 'h0A00);
    chk(!ovf_o, "R9", "seventh fork accepted", int'(ovf_o), 0);
    submit(jd_pkg::KIND_FORK, 0, 0, 'h08FF, 'h0B00);
    chk(ovf_o && !redir_valid_o, "R9", "fork on full pool",
        int'({ovf_o, redir_valid_o}), 2);
    submit(jd_pkg::KIND_SEL, 2, 2, 'h0901, 0);
    chk(!ovf_o, "R9", "merge on full pool", int'(ovf_o), 0);
    submit(jd_pkg::KIND_SEL, 2, 1, 'h0902, 0);
    chk(ovf_o, "R9", "new selection on full pool", int'(ovf_o), 1);
    idle(1);
    chk(!ovf_o, "R9", "overflow one cycle", int'(ovf_o), 0);
    for (int i = 0; i < 7; i++) begin
      chk(sup_valid_o && sup_addr_o == AW'('h0800 + i), "R9", "parked order",
          int'(sup_addr_o), 'h0800 + i);
      pop_sup();
    end
    chk(!sup_valid_o, "R9", "dropped fork absent", int'(sup_valid_o), 0);
    expect_disp(2, 'h0901, "R9");
    finish_units(4'b0100);
    drain("R9");
    finish_units(4'b0100);
    idle(4);
    chk(!unit_busy_o[2], "R9", "dropped selection absent", int'(unit_busy_o[2]), 0);
    chk(exp_unit.size() == 0, "R9", "scoreboard empty", exp_unit.size(), 0);

    summary();
  end
endmodule